// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block sends 8-bit or 9-bit words over a two-wire synchronous link and generates the shift clock itself. A host places each word in a single holding register. When the shift register is free, the word moves across in one system clock, and the shift register sends it out least significant bit first. A programmable divider sets the pace. Because there are two registers, the host can queue one word while the previous word is still being shifted, and consecutive words leave the block with no gap between them.

The host has two status outputs. The first is a holding-empty flag, which can also drive an interrupt line. It is set when a word moves into the shift register, and only a new accepted write clears it. The second is a shift-empty bit, which the host polls to learn when the last bit has left the block. The idle level of the clock line is selectable. The link is half-duplex. When the transmit enable is low, the block drops any word in progress, empties both registers and releases the data line.

Top module: `sst_master_tx`

## Requirements
- R1: After reset, `ser_clk` is at the idle level given by `clk_idle_high`, `shift_empty` is 1, `tx_flag` is 1 and `overrun` is 0.
- R2: When `clk_idle_high` is 1 the clock idles high and pulses low. When it is 0 the clock idles low and pulses high. While nothing is being shifted, the clock stays at its idle level.
- R3: Bits leave the block least significant first, one bit per clock pulse, with `ser_data` sampled on the idle-to-active clock transition. Data bits 0 to 7 are sent first. When `nine_bit_en` is 1 at the transfer, the value of `ninth_bit` captured with the write is sent as a ninth bit.
- R4: One bit lasts (`baud_div`+1)×4 system clocks. The first half of a bit is spent at the idle clock level and the second half at the active level. After a transfer, the first active level appears (`baud_div`+1)×2 clocks later.
- R5: A write (`wr_valid` high while `tx_en` is 1 and the holding register is empty) makes `tx_flag` 0 on the next cycle. One cycle after that, the word moves to the shift register: `tx_flag` returns to 1 and `shift_empty` goes to 0.
- R6: Only an accepted write clears `tx_flag`. `tx_irq` equals `tx_flag` AND `tx_irq_en`.
- R7: A word that is waiting when the last bit of the current word ends is transferred on that same clock edge. The next word follows with no gap, and `tx_flag` rises exactly one word time after the first transfer.
- R8: `shift_empty` goes to 1 exactly N×(`baud_div`+1)×4 clocks after the transfer of the last queued word, where N is 8 or 9.
- R9: `ser_data` changes only while `ser_clk` is at its idle level.
- R10: A write while the holding register is full is ignored. `overrun` is high for one cycle, the cycle after that write.
- R11: While `tx_en` is 0, `ser_data_oe` is 0. Dropping `tx_en` aborts the word in progress: on the next cycle both registers are empty and the clock is idle. Writes made while disabled are ignored and do not raise `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; low aborts and releases the data line |
| nine_bit_en | input | 1 | Send a ninth bit after the eight data bits |
| clk_idle_high | input | 1 | Clock idle level (1 = high) |
| baud_div | input | DIV_W | Bit period divider; period is (value+1)×4 clocks |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data word to send |
| ninth_bit | input | 1 | Ninth bit captured with the write |
| tx_irq_en | input | 1 | Interrupt enable for the holding-empty flag |
| ser_clk | output | 1 | Master-generated shift clock |
| ser_data | output | 1 | Serial data |
| ser_data_oe | output | 1 | Output enable for the data line |
| tx_flag | output | 1 | Holding register empty |
| tx_irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | Shift register empty |
| overrun | output | 1 | One-cycle pulse for a write rejected because the register was full |

## Verification
Counting from the edge that accepts a write, `tx_flag` is due low one cycle later. `tx_flag` back high and `shift_empty` low are due a cycle after that. From that transfer edge, the first active clock half is due (`baud_div`+1)×2 cycles later, and `shift_empty` returns after the full word count times four times (`baud_div`+1). The bench drives inputs on falling edges and counts falling edges from the transfer edge, so each result is compared at the exact cycle derived from those formulas. A queued second word must raise `tx_flag` exactly one word time after the first transfer. `overrun` is expected exactly one cycle after the rejected write. The effects of an abort are expected on the cycle after `tx_en` drops.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned WORD_W = 8;

  // Shift frame: data byte plus optional ninth bit in the top position.
  typedef logic [WORD_W:0] frame_t;

  // System clocks spent in one clock half (idle or active).
  function automatic logic [31:0] half_len(input logic [31:0] div);
    return (div + 32'd1) << 1;
  endfunction

  // Index of the final bit of a frame.
  function automatic logic [3:0] last_index(input logic nine);
    return nine ? 4'd8 : 4'd7;
  endfunction
endpackage

// File: rtl/sst_baud.sv
module sst_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             half_end
);
  localparam int unsigned CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [31:0]      half_m1;

  assign half_m1  = sst_pkg::half_len(32'(div)) - 32'd1;
  assign half_end = run && ({{(32-CNT_W){1'b0}}, cnt} == half_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run || half_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sst_hold.sv
module sst_hold (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              wr_ninth,
  input  logic              take,
  output logic              full,
  output sst_pkg::frame_t   frame,
  output logic              overrun
);
  logic accept;

  assign accept = wr_valid && enable && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      frame   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= wr_valid && enable && full;
      if (!enable) begin
        full <= 1'b0;
      end else if (accept) begin
        full  <= 1'b1;
        frame <= {wr_ninth, wr_data};
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sst_shift.sv
module sst_shift (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort,
  input  logic            load,
  input  sst_pkg::frame_t load_frame,
  input  logic            load_nine,
  input  logic            half_end,
  output logic            busy,
  output logic            active,
  output logic            sdat,
  output logic            last_end
);
  sst_pkg::frame_t sreg;
  logic [3:0]      idx;
  logic [3:0]      last_idx;

  assign last_end = busy && half_end && active && (idx == last_idx);
  assign sdat     = busy && sreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      active   <= 1'b0;
      sreg     <= '0;
      idx      <= '0;
      last_idx <= 4'd7;
    end else if (abort) begin
      busy   <= 1'b0;
      active <= 1'b0;
      sreg   <= '0;
      idx    <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      active   <= 1'b0;
      sreg     <= load_frame;
      idx      <= '0;
      last_idx <= sst_pkg::last_index(load_nine);
    end else if (busy && half_end) begin
      if (!active) begin
        active <= 1'b1;
      end else begin
        active <= 1'b0;
        if (idx == last_idx) begin
          busy <= 1'b0;
          sreg <= '0;
          idx  <= '0;
        end else begin
          idx  <= idx + 1'b1;
          sreg <= sreg >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/sst_master_tx.sv
module sst_master_tx #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             nine_bit_en,
  input  logic             clk_idle_high,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             ninth_bit,
  input  logic             tx_irq_en,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             ser_data_oe,
  output logic             tx_flag,
  output logic             tx_irq,
  output logic             shift_empty,
  output logic             overrun
);
  logic            hold_full;
  sst_pkg::frame_t hold_frame;
  logic            load;
  logic            busy;
  logic            active;
  logic            sdat;
  logic            last_end;
  logic            half_end;

  // Transfer event: a queued word and a shifter that is free or finishing.
  assign load = tx_en && hold_full && (!busy || last_end);

  sst_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (tx_en),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .wr_ninth (ninth_bit),
    .take     (load),
    .full     (hold_full),
    .frame    (hold_frame),
    .overrun  (overrun)
  );

  sst_baud #(.DIV_W(DIV_W)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy && tx_en),
    .restart  (load),
    .div      (baud_div),
    .half_end (half_end)
  );

  sst_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (!tx_en),
    .load       (load),
    .load_frame (hold_frame),
    .load_nine  (nine_bit_en),
    .half_end   (half_end),
    .busy       (busy),
    .active     (active),
    .sdat       (sdat),
    .last_end   (last_end)
  );

  assign ser_clk     = (busy && active) ? ~clk_idle_high : clk_idle_high;
  assign ser_data    = sdat;
  assign ser_data_oe = tx_en;
  assign tx_flag     = !hold_full;
  assign tx_irq      = tx_flag && tx_irq_en;
  assign shift_empty = !busy;
endmodule

// File: rtl/sst_master_tx_chk.sv
module sst_master_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic clk_idle_high,
  input logic wr_valid,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_data_oe,
  input logic tx_flag,
  input logic shift_empty,
  input logic overrun,
  input logic hold_full,
  input logic load,
  input logic last_end
);
  p_idle_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> (ser_clk == clk_idle_high));

  p_data_moves_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $stable(clk_idle_high) && !$stable(ser_data)) |-> (ser_clk == clk_idle_high));

  p_flag_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_flag) |-> $past(wr_valid && tx_en));

  p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> ($past(load) || $past(!tx_en)));

  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (shift_empty || last_end));

  p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(wr_valid && tx_en && hold_full));

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !ser_data_oe);

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (shift_empty && tx_flag));
endmodule

bind sst_master_tx sst_master_tx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_en         (tx_en),
  .clk_idle_high (clk_idle_high),
  .wr_valid      (wr_valid),
  .ser_clk       (ser_clk),
  .ser_data      (ser_data),
  .ser_data_oe   (ser_data_oe),
  .tx_flag       (tx_flag),
  .shift_empty   (shift_empty),
  .overrun       (overrun),
  .hold_full     (hold_full),
  .load          (load),
  .last_end      (last_end)
);

// File: tb/sst_master_tx_bench.sv
module sst_master_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b1;
  logic       nine_bit_en = 1'b0;
  logic       clk_idle_high = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       ninth_bit = 1'b0;
  logic       tx_irq_en = 1'b0;
  logic       ser_clk, ser_data, ser_data_oe, tx_flag, tx_irq, shift_empty, overrun;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sst_master_tx #(.DIV_W(8)) u_sst_master_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .nine_bit_en(nine_bit_en),
    .clk_idle_high(clk_idle_high), .baud_div(baud_div), .wr_valid(wr_valid),
    .wr_data(wr_data), .ninth_bit(ninth_bit), .tx_irq_en(tx_irq_en),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_data_oe(ser_data_oe),
    .tx_flag(tx_flag), .tx_irq(tx_irq), .shift_empty(shift_empty), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sends word a (a[8] = ninth bit), optionally a queued word b, optionally a
  // rejected third write; checks timing and the captured bit stream.
  task automatic xfer(input logic [8:0] a, input bit two, input logic [8:0] b, input bit extra);
    int nb   = nine_bit_en ? 9 : 8;
    int half = (int'(baud_div) + 1) * 2;
    int word = nb * 2 * half;
    int nw   = two ? 2 : 1;
    int t = 0, cap = 0, first_act = -1, last_act = -1, t_rise = -1;
    bit bad_move = 0, bad_period = 0, bad_irq = 0, bad_bits = 0, bad_ovr = 0;
    logic prev_clk, prev_d, prev_flag, exp_bit;
    logic got [0:17];
    @(negedge clk);
    wr_data = a[7:0]; ninth_bit = a[8]; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(tx_flag == 1'b0, "R5 flag low after write", int'(tx_flag), 0);
    @(negedge clk);
    chk(tx_flag == 1'b1 && shift_empty == 1'b0, "R5 transfer next cycle",
        int'({tx_flag, shift_empty}), 2);
    if (two) begin
      wr_data = b[7:0]; ninth_bit = b[8]; wr_valid = 1'b1;
    end
    prev_clk = ser_clk; prev_d = ser_data; prev_flag = tx_flag;
    while (!shift_empty && t < 5000) begin
      @(negedge clk);
      t++;
      if (t == 1) begin
        if (two) chk(tx_flag == 1'b0, "R6 flag low while queued", int'(tx_flag), 0);
        if (extra) begin
          wr_data = 8'h3C; ninth_bit = ~b[8];
        end else begin
          wr_valid = 1'b0;
        end
      end
      if (t == 2) begin
        wr_valid = 1'b0;
        if (extra) chk(overrun == 1'b1, "R10 overrun pulse", int'(overrun), 1);
      end else if (overrun) begin
        bad_ovr = 1;
      end
      if (tx_irq != (tx_flag && tx_irq_en)) bad_irq = 1;
      if (tx_flag && !prev_flag && t_rise < 0) t_rise = t;
      if (ser_clk != clk_idle_high && prev_clk == clk_idle_high) begin
        if (first_act < 0) first_act = t;
        if (last_act >= 0 && (t - last_act) != 2 * half) bad_period = 1;
        last_act = t;
        if (cap < 18) got[cap] = ser_data;
        cap++;
      end
      if (ser_clk != clk_idle_high && prev_clk != clk_idle_high && ser_data != prev_d) bad_move = 1;
      prev_clk = ser_clk; prev_d = ser_data; prev_flag = tx_flag;
    end
    chk(t == nw * word, "R8 shift_empty after frame", t, nw * word);
    chk(first_act == half, "R4 first active half", first_act, half);
    chk(!bad_period, "R4 bit period", int'(bad_period), 0);
    chk(ser_clk == clk_idle_high, "R2 clock idle after frame", int'(ser_clk), int'(clk_idle_high));
    chk(cap == nw * nb, "R3 bit count", cap, nw * nb);
    for (int i = 0; i < nw * nb && i < 18; i++) begin
      exp_bit = (i < nb) ? a[i] : b[i - nb];
      if (got[i] !== exp_bit) bad_bits = 1;
    end
    chk(!bad_bits, "R3 LSB-first data", int'(bad_bits), 0);
    chk(!bad_move, "R9 data stable while active", int'(bad_move), 0);
    chk(!bad_irq, "R6 irq follows flag and enable", int'(bad_irq), 0);
    if (two) chk(t_rise == word, "R7 second transfer without gap", t_rise, word);
    if (extra) chk(!bad_ovr, "R10 overrun one cycle only", int'(bad_ovr), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state with low idle level
    chk(ser_clk == 1'b0, "R1 clock idle low", int'(ser_clk), 0);
    chk(shift_empty && tx_flag && !overrun, "R1 status after reset",
        int'({shift_empty, tx_flag, overrun}), 6);
    rst_n = 1'b1;
    @(negedge clk);
    clk_idle_high = 1'b1;
    #1;
    chk(ser_clk == 1'b1, "R2 idle high level", int'(ser_clk), 1);
    // R6 interrupt gating
    chk(tx_irq == 1'b0, "R6 irq masked", int'(tx_irq), 0);
    tx_irq_en = 1'b1;
    #1;
    chk(tx_irq == 1'b1, "R6 irq on empty flag", int'(tx_irq), 1);

    // Sweep divider, word size, polarity; single and back-to-back words
    for (int d = 0; d < 4; d++) begin
      for (int n = 0; n < 2; n++) begin
        for (int p = 0; p < 2; p++) begin
          @(negedge clk);
          baud_div = 8'(d); nine_bit_en = n[0]; clk_idle_high = p[0];
          tx_irq_en = d[0];
          xfer({1'(p ^ d), 8'hA5 ^ 8'(d * 37 + n * 11 + p)}, 1'b0, 9'h0, 1'b0);
          xfer({1'(~p), 8'h5A ^ 8'(d * 13)}, 1'b1, {1'(n), 8'h0F + 8'(p * 64)}, 1'b0);
        end
      end
    end

    // R10: third write while holding register is full is rejected
    @(negedge clk);
    baud_div = 8'd1; nine_bit_en = 1'b1; clk_idle_high = 1'b0;
    xfer(9'h1C3, 1'b1, 9'h066, 1'b1);

    // Longer divider
    @(negedge clk);
    baud_div = 8'd20; nine_bit_en = 1'b0;
    xfer(9'h081, 1'b0, 9'h0, 1'b0);

    // R11 abort mid-word with a queued word
    @(negedge clk);
    baud_div = 8'd3; clk_idle_high = 1'b1;
    wr_data = 8'hF0; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
    @(negedge clk); wr_data = 8'h11; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(!shift_empty && !tx_flag, "R11 busy before abort", int'({shift_empty, tx_flag}), 0);
    tx_en = 1'b0;
    #1;
    chk(ser_data_oe == 1'b0, "R11 data line released", int'(ser_data_oe), 0);
    @(negedge clk);
    chk(shift_empty && tx_flag && ser_clk == clk_idle_high, "R11 abort empties both",
        int'({shift_empty, tx_flag, ser_clk}), 7);
    wr_data = 8'h77; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
    chk(tx_flag == 1'b1 && overrun == 1'b0, "R11 write ignored while disabled",
        int'({tx_flag, overrun}), 2);
    @(negedge clk);
    chk(shift_empty == 1'b1, "R11 nothing shifted while disabled", int'(shift_empty), 1);
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(shift_empty && tx_flag, "R11 still empty after re-enable", int'({shift_empty, tx_flag}), 3);
    xfer(9'h03C, 1'b0, 9'h0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule